// File: doc/BRIEF.md
# Capture/Reload Timer with Clock-Out

This block is a 16-bit up-counter with a companion 16-bit holding register that serves either as the reload source or as the capture target. Each step of the counter comes from one of two places: an internal tick strobe, or a falling edge on an external count pin. The counter advances only while the run bit is set. When it passes its top value it either takes the holding value (reload behaviour) or wraps to zero (capture behaviour). Each overflow can also flip a clock-out pin.

A falling edge on the external trigger pin acts only when the trigger-enable bit is set. In reload behaviour it reloads the counter early. In capture behaviour it copies the live count into the holding register. When either of the two baud-request inputs is high, reload behaviour is forced and trigger edges do not capture. An overflow flag and a trigger flag are sticky, and their OR forms the interrupt. Software reaches the block through a byte-wide register port. Writes are strobed and reads are combinational.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset every register reads zero, and `irq` and `clk_out` are low. The register map is: address 0 = control, 1 = count low byte, 2 = count high byte, 3 = holding low byte, 4 = holding high byte. The control byte holds: bit0 run, bit1 capture-select, bit2 trigger-enable, bit3 count-source (1 = count pin), bit4 clock-out enable, bit5 overflow flag, bit6 trigger flag, bit7 reads zero.
- R2: With run set and count-source 0, the count rises by one on each cycle in which `tick` is high. With run clear, `tick` leaves the count unchanged.
- R3: In reload behaviour, a step taken from 0xFFFF loads the holding value into the count and sets the overflow flag.
- R4: With count-source 1, the count rises by one per falling edge on `cnt_pin`, seen through a two-flop synchronizer, and `tick` is ignored.
- R5: With trigger-enable set, capture-select 0 and no baud request, a synchronized falling edge on `trig_pin` loads the holding value into the count and sets the trigger flag.
- R6: With trigger-enable set, capture-select 1 and no baud request, a trigger edge copies the count into the holding register and leaves the count alone. In this behaviour an overflow wraps the count to 0.
- R7: With trigger-enable clear, a trigger edge changes neither the count, the holding register nor the flags.
- R8: While `baud_rx_req` or `baud_tx_req` is high, overflow reloads even with capture-select 1. A trigger edge then sets only the trigger flag and does not capture.
- R9: With clock-out enable set, each overflow inverts `clk_out`. With it clear, `clk_out` holds its level.
- R10: `irq` is high whenever either flag is set. The flags stay set until software writes the control byte with those bits at 0.
- R11: A software write to a count byte in the same cycle as an overflow wins over the hardware reload. The other count byte keeps its prior value, and the overflow flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal count strobe |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| baud_rx_req | input | 1 | Receive baud request, forces reload behaviour |
| baud_tx_req | input | 1 | Transmit baud request, forces reload behaviour |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt, set while any flag is set |
| clk_out | output | 1 | Overflow-toggled clock output |

## Verification
A wrong count or holding value shows up on `rd_data` in the cycle after the faulty step. Every directed scenario ends by reading both 16-bit registers back through the port. A lost or stray flag shows at once on `irq` and in control bits 5 and 6. A missed or extra toggle leaves `clk_out` at the wrong level after a known number of overflows. Pin-driven faults (a wrong edge polarity, a synchronizer of the wrong depth, the wrong trigger action under a baud request) appear within four cycles of the pin edge. The bench allows that many cycles before it reads back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DW    = 8;
    localparam int NB    = 2;
    localparam int CW    = DW * NB;
    localparam int AW    = 3;
    localparam int SYNC  = 2;

    typedef struct packed {
        logic ext_flag;
        logic ovf_flag;
        logic clko_en;
        logic ext_src;
        logic ext_en;
        logic cap_sel;
        logic run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam logic [AW-1:0] A_CTL = '0;

    function automatic logic [AW-1:0] cnt_addr(input int b);
        return AW'(1 + b);
    endfunction

    function automatic logic [AW-1:0] rld_addr(input int b);
        return AW'(1 + NB + b);
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[STAGES-1:0], pin};
    end

    assign fall = hist_q[STAGES] & ~hist_q[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int DW = 8,
    parameter int NB = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    input  logic               reload_on_ovf,
    input  logic               trig_reload,
    input  logic               trig_capture,
    input  logic [NB-1:0]      wr_cnt,
    input  logic [NB-1:0]      wr_rld,
    input  logic [DW-1:0]      wdata,
    output logic [DW*NB-1:0]   cnt,
    output logic [DW*NB-1:0]   rld,
    output logic               ovf
);
    localparam int CW = DW * NB;

    logic [CW-1:0] cnt_q, rld_q, cnt_wr, rld_wr;

    always_comb begin
        cnt_wr = cnt_q;
        rld_wr = rld_q;
        for (int b = 0; b < NB; b++) begin
            if (wr_cnt[b]) cnt_wr[b*DW +: DW] = wdata;
            if (wr_rld[b]) rld_wr[b*DW +: DW] = wdata;
        end
    end

    assign ovf = inc & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            if (|wr_cnt)
                cnt_q <= cnt_wr;
            else if ((ovf && reload_on_ovf) || trig_reload)
                cnt_q <= rld_q;
            else if (inc)
                cnt_q <= cnt_q + CW'(1);

            if (|wr_rld)
                rld_q <= rld_wr;
            else if (trig_capture)
                rld_q <= cnt_q;
        end
    end

    assign cnt = cnt_q;
    assign rld = rld_q;
endmodule

// File: rtl/tmr_clkout.sv
module tmr_clkout (
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic q
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)       q_r <= 1'b0;
        else if (flip) q_r <= ~q_r;
    end

    assign q = q_r;
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cnt_pin,
    input  logic          trig_pin,
    input  logic          baud_rx_req,
    input  logic          baud_tx_req,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    output logic          clk_out
);
    ctl_t          ctl_q, ctl_d;
    logic          wr_ctl, wr_cnt_any, wr_rld_any;
    logic [NB-1:0] wr_cnt, wr_rld;
    logic          cnt_fall, trig_fall, trig_evt, baud_any;
    logic          inc, ovf, reload_on_ovf, trig_reload, trig_capture;
    logic [CW-1:0] cnt, rld;

    // Address decode
    always_comb begin
        wr_ctl = wr_en && (wr_addr == A_CTL);
        for (int b = 0; b < NB; b++) begin
            wr_cnt[b] = wr_en && (wr_addr == cnt_addr(b));
            wr_rld[b] = wr_en && (wr_addr == rld_addr(b));
        end
    end
    assign wr_cnt_any = |wr_cnt;
    assign wr_rld_any = |wr_rld;

    // Pin synchronizers
    tmr_edge_sync #(.STAGES(SYNC)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall));
    tmr_edge_sync #(.STAGES(SYNC)) u_trig_sync (
        .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall));

    // Mode resolution
    assign baud_any      = baud_rx_req | baud_tx_req;
    assign trig_evt      = ctl_q.ext_en & trig_fall;
    assign reload_on_ovf = baud_any | ~ctl_q.cap_sel;
    assign trig_reload   = trig_evt & ~ctl_q.cap_sel & ~baud_any;
    assign trig_capture  = trig_evt &  ctl_q.cap_sel & ~baud_any;
    assign inc           = ctl_q.run & (ctl_q.ext_src ? cnt_fall : tick);

    tmr_core #(.DW(DW), .NB(NB)) u_core (
        .clk(clk), .rst(rst), .inc(inc), .reload_on_ovf(reload_on_ovf),
        .trig_reload(trig_reload), .trig_capture(trig_capture),
        .wr_cnt(wr_cnt), .wr_rld(wr_rld), .wdata(wr_data),
        .cnt(cnt), .rld(rld), .ovf(ovf));

    tmr_clkout u_clkout (
        .clk(clk), .rst(rst), .flip(ovf & ctl_q.clko_en), .q(clk_out));

    // Control byte with sticky flags; a hardware set wins over a clear
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
        ctl_d.ovf_flag = ctl_d.ovf_flag | ovf;
        ctl_d.ext_flag = ctl_d.ext_flag | trig_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign irq = ctl_q.ovf_flag | ctl_q.ext_flag;

    // Read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTL) rd_data = {{(DW-CTL_W){1'b0}}, ctl_q};
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == cnt_addr(b)) rd_data = cnt[b*DW +: DW];
            if (rd_addr == rld_addr(b)) rd_data = rld[b*DW +: DW];
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input ctl_t          ctl,
    input logic          wr_ctl,
    input logic          wr_cnt_any,
    input logic          wr_rld_any,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] rld,
    input logic          ovf,
    input logic          trig_evt,
    input logic          baud_any,
    input logic          clk_out
);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !wr_cnt_any && !trig_evt) |=> $stable(cnt));

    p_ovf_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf && (!ctl.cap_sel || baud_any) && !wr_cnt_any) |=> (cnt == $past(rld)));

    p_ext_flag_r5: assert property (@(posedge clk) disable iff (rst)
        trig_evt |=> ctl.ext_flag);

    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (trig_evt && ctl.cap_sel && !baud_any && !wr_rld_any) |=> (rld == $past(cnt)));

    p_clk_flip_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf && ctl.clko_en) |=> (clk_out != $past(clk_out)));

    p_clk_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(ovf && ctl.clko_en) |=> $stable(clk_out));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl.ovf_flag && !wr_ctl) |=> ctl.ovf_flag);
endmodule

bind cap_reload_timer tmr_checker chk_i (
    .clk(clk), .rst(rst), .ctl(ctl_q), .wr_ctl(wr_ctl),
    .wr_cnt_any(wr_cnt_any), .wr_rld_any(wr_rld_any),
    .cnt(cnt), .rld(rld), .ovf(ovf), .trig_evt(trig_evt),
    .baud_any(baud_any), .clk_out(clk_out));

// File: tb/cap_reload_timer_tb_top.sv
module cap_reload_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
    logic       baud_rx_req = 1'b0, baud_tx_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       irq, clk_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cap_reload_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .baud_rx_req(baud_rx_req), .baud_tx_req(baud_tx_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .clk_out(clk_out));

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 3'd1, v[15:8]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l); rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic trig_pulse();
        @(negedge clk); trig_pin = 1'b0;
        repeat (4) @(negedge clk); trig_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cnt_pulse();
        @(negedge clk); cnt_pin = 1'b0;
        repeat (4) @(negedge clk); cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 register reset", {8'h0, v}, 16'h0);
        end
        check("R1 irq reset", {15'h0, irq}, 16'h0);
        check("R1 clk_out reset", {15'h0, clk_out}, 16'h0);
    endtask

    task automatic t_tick_count();
        logic [15:0] v;
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h01);
        ticks(5);
        rd16(3'd1, v); check("R2 counts ticks", v, 16'h0005);
        wr(3'd0, 8'h00);
        ticks(5);
        rd16(3'd1, v); check("R2 halted when not running", v, 16'h0005);
    endtask

    task automatic t_reload();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd3, 16'h1234);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, 8'h01);
        ticks(3);
        rd16(3'd1, v); check("R3 reload after overflow", v, 16'h1235);
        rd(3'd0, c); check("R3 overflow flag", {8'h0, c}, 16'h0021);
        repeat (3) @(negedge clk);
        check("R10 irq from sticky flag", {15'h0, irq}, 16'h1);
        wr(3'd0, 8'h00);
        check("R10 irq after clear", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_clkout();
        wr16(3'd3, 16'hFFFF);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h11);
        ticks(3);
        check("R9 three toggles", {15'h0, clk_out}, 16'h1);
        wr(3'd0, 8'h01);
        ticks(2);
        check("R9 held when disabled", {15'h0, clk_out}, 16'h1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_capture();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd1, 16'h0100);
        wr16(3'd3, 16'h0000);
        wr(3'd0, 8'h06);
        trig_pulse();
        rd16(3'd3, v); check("R6 captured count", v, 16'h0100);
        rd16(3'd1, v); check("R6 count untouched", v, 16'h0100);
        rd(3'd0, c); check("R5 trigger flag in capture", {8'h0, c}, 16'h0046);
        check("R10 irq from trigger flag", {15'h0, irq}, 16'h1);
        wr16(3'd1, 16'hFFFF);
        wr16(3'd3, 16'h5555);
        wr(3'd0, 8'h03);
        ticks(1);
        rd16(3'd1, v); check("R6 wrap to zero", v, 16'h0000);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_reload();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd1, 16'h0042);
        wr16(3'd3, 16'hBEEF);
        wr(3'd0, 8'h04);
        trig_pulse();
        rd16(3'd1, v); check("R5 trigger reload", v, 16'hBEEF);
        rd(3'd0, c); check("R5 trigger flag", {8'h0, c}, 16'h0044);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_off();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd1, 16'h0042);
        wr(3'd0, 8'h00);
        trig_pulse();
        rd16(3'd1, v); check("R7 no reload when disabled", v, 16'h0042);
        wr(3'd0, 8'h02);
        trig_pulse();
        rd16(3'd3, v); check("R7 no capture when disabled", v, 16'hBEEF);
        rd(3'd0, c); check("R7 no flag when disabled", {8'h0, c}, 16'h0002);
        check("R7 irq low", {15'h0, irq}, 16'h0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_baud();
        logic [15:0] v; logic [7:0] c;
        baud_rx_req = 1'b1;
        wr16(3'd3, 16'h7000);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h03);
        ticks(1);
        rd16(3'd1, v); check("R8 forced reload", v, 16'h7000);
        baud_rx_req = 1'b0; baud_tx_req = 1'b1;
        wr(3'd0, 8'h06);
        wr16(3'd1, 16'h0033);
        trig_pulse();
        rd16(3'd3, v); check("R8 no capture under baud", v, 16'h7000);
        rd16(3'd1, v); check("R8 count kept under baud", v, 16'h0033);
        rd(3'd0, c); check("R8 trigger flag only", {8'h0, c}, 16'h0046);
        baud_tx_req = 1'b0;
        wr(3'd0, 8'h00);
    endtask

    task automatic t_ext_count();
        logic [15:0] v;
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h09);
        tick = 1'b1;
        repeat (3) cnt_pulse();
        tick = 1'b0;
        rd16(3'd1, v); check("R4 counts pin edges", v, 16'h0003);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_priority();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd3, 16'h1111);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h01);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h22;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd16(3'd1, v); check("R11 write beats reload", v, 16'hFF22);
        rd(3'd0, c); check("R11 flag still set", {8'h0, c}, 16'h0021);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tick_count();
        t_reload();
        t_clkout();
        t_capture();
        t_trig_reload();
        t_trig_off();
        t_baud();
        t_ext_count();
        t_priority();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule